// File: doc/BRIEF.md
# DMA Channel Request Arbiter

This block sits in front of the transfer engine of an eight-channel DMA controller and decides which channel is served next. Each channel offers an external single request, an external burst request and a software request pulse. Per-channel control vectors say whether the channel is enabled, whether its external requests are masked, whether it answers only burst requests, whether it sits at the high priority level, and whether it needs a hold-until-deassert handshake.

Whenever no channel is active, the engine reports idle and the global enable is set, the arbiter picks one qualified channel. It then issues a one-cycle registered grant strobe that carries the channel index and a burst flag. The granted channel stays active until the engine pulses its service-done input. A channel with the handshake bit set stays active after service until its raw request input falls. Software pulses are remembered until their channel is granted.

Top module: `dma_req_arbiter`

## Requirements
- R1: A channel can be granted only while its `ch_en` bit is 1 and `glb_en` is 1; with `glb_en` at 0 no grant is issued at all.
- R2: A channel whose `ch_mask` bit is 1 ignores its `req_single` and `req_burst` inputs, but a software request on it is still served.
- R3: A channel whose `ch_burst_only` bit is 1 ignores `req_single`; only `req_burst` or a software request makes it eligible.
- R4: A one-cycle `sw_req` pulse on an enabled channel is held pending until that channel is granted, and the grant clears it, so one pulse yields exactly one grant.
- R5: If any eligible channel has its `ch_hipri` bit at 1, the grant goes to a channel of that high level, never to a default-level channel.
- R6: Within the winning priority level the lowest channel number is granted (`gnt_ch` is the binary channel index, bit i of each vector belongs to channel i).
- R7: `gnt_valid` is high for exactly one cycle per grant, one cycle after a clock edge at which `eng_idle` was 1 and no channel was active; a grant is never issued while a channel is active.
- R8: From the edge that raises `gnt_valid`, `ch_active` is one-hot on the granted channel. It returns to all-zero at the edge that samples `svc_done` high, provided the channel's `ch_waitreq` bit is 0 or its raw request is low.
- R9: If the serviced channel's `ch_waitreq` bit is 1 and its `req_single` or `req_burst` input is high when `svc_done` is sampled, it stays active, blocking all grants, until both of those inputs are low. It is released at the edge that samples them low.
- R10: A pending software request is dropped when its channel's `ch_en` bit is 0 at a clock edge; a `sw_req` pulse on a disabled channel is not recorded.
- R11: After synchronous reset `gnt_valid` is 0, `ch_active` is all-zero and no software request is pending.
- R12: `gnt_burst` is 1 when the granted channel had an unmasked `req_burst` at the arbitration edge, and 0 when it was granted on a single or software request only.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| glb_en | input | 1 | Global controller enable |
| ch_en | input | NUM_CH | Per-channel enable |
| ch_mask | input | NUM_CH | Per-channel external request mask |
| ch_burst_only | input | NUM_CH | Per-channel ignore-single-requests control |
| ch_hipri | input | NUM_CH | Per-channel high priority select |
| ch_waitreq | input | NUM_CH | Per-channel hold-until-request-drops select |
| req_single | input | NUM_CH | External single requests |
| req_burst | input | NUM_CH | External burst requests |
| sw_req | input | NUM_CH | Software request pulses |
| eng_idle | input | 1 | Transfer engine can accept a new channel |
| svc_done | input | 1 | Engine has finished serving the active channel |
| gnt_valid | output | 1 | One-cycle grant strobe |
| gnt_ch | output | IDX_W | Granted channel index |
| gnt_burst | output | 1 | Grant was for a burst request |
| ch_active | output | NUM_CH | One-hot active channel, zero when none |

## Verification
The bench goes after the handshake hold: a design that released the channel at `svc_done` would let a second channel in while the first still drives its request. It also targets a masked burst request coexisting with a software pulse, where a wrong design either loses the software grant or reports it as a burst. Pending software pulses are checked across a disabled cycle, where a sticky bit would produce a phantom grant. A design that let priority override enable or mis-ordered lowest-index selection would produce a wrong `gnt_ch` under mixed random vectors checked against a bench reference each cycle.

// File: rtl/dma_arb_pkg.sv
package dma_arb_pkg;
  typedef enum logic [1:0] {
    ARB_IDLE = 2'd0,
    ARB_BUSY = 2'd1,
    ARB_HOLD = 2'd2
  } arb_state_e;
endpackage

// File: rtl/dma_req_qualify.sv
// Per-channel request qualification plus the software-request pending latch.
module dma_req_qualify #(
  parameter int NUM_CH = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              glb_en,
  input  logic [NUM_CH-1:0] ch_en,
  input  logic [NUM_CH-1:0] ch_mask,
  input  logic [NUM_CH-1:0] ch_burst_only,
  input  logic [NUM_CH-1:0] req_single,
  input  logic [NUM_CH-1:0] req_burst,
  input  logic [NUM_CH-1:0] sw_req,
  input  logic [NUM_CH-1:0] gnt_clr,
  output logic [NUM_CH-1:0] cand,
  output logic [NUM_CH-1:0] cand_burst
);
  logic [NUM_CH-1:0] sw_pend;

  for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
    logic ext_single;
    logic ext_burst;
    logic live;

    // R3: single requests drop out on burst-only channels; R2: mask kills both external kinds
    assign ext_single = req_single[i] & ~ch_burst_only[i] & ~ch_mask[i];
    assign ext_burst  = req_burst[i] & ~ch_mask[i];
    assign live       = ch_en[i] & glb_en;

    assign cand[i]       = live & (ext_single | ext_burst | sw_pend[i]);
    assign cand_burst[i] = live & ext_burst;

    // R4 / R10: pulse is kept until granted, dropped while the channel is disabled
    always_ff @(posedge clk) begin
      if (rst) begin
        sw_pend[i] <= 1'b0;
      end else begin
        sw_pend[i] <= ((sw_pend[i] & ~gnt_clr[i]) | sw_req[i]) & ch_en[i];
      end
    end
  end
endmodule

// File: rtl/dma_prio_pick.sv
// Two-level priority selection, lowest index wins inside a level.
module dma_prio_pick #(
  parameter int NUM_CH = 8,
  parameter int IDX_W  = $clog2(NUM_CH)
) (
  input  logic [NUM_CH-1:0] cand,
  input  logic [NUM_CH-1:0] hipri,
  output logic              any,
  output logic [IDX_W-1:0]  idx
);
  logic [NUM_CH-1:0] hi_set;
  logic [NUM_CH-1:0] level;

  assign hi_set = cand & hipri;
  assign level  = (|hi_set) ? hi_set : cand;
  assign any    = |cand;

  always_comb begin
    idx = '0;
    for (int i = NUM_CH - 1; i >= 0; i--) begin
      if (level[i]) idx = IDX_W'(i);
    end
  end
endmodule

// File: rtl/dma_chan_tracker.sv
// Tracks the channel in service and the post-service request handshake.
module dma_chan_tracker
  import dma_arb_pkg::*;
#(
  parameter int NUM_CH = 8,
  parameter int IDX_W  = $clog2(NUM_CH)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [IDX_W-1:0]  start_idx,
  input  logic              svc_done,
  input  logic [NUM_CH-1:0] ch_waitreq,
  input  logic [NUM_CH-1:0] req_raw,
  output logic              idle,
  output logic [NUM_CH-1:0] ch_active
);
  arb_state_e       state, nstate;
  logic [IDX_W-1:0] cur, ncur;

  always_comb begin
    nstate = state;
    ncur   = cur;
    unique case (state)
      ARB_IDLE: begin
        if (start) begin
          nstate = ARB_BUSY;
          ncur   = start_idx;
        end
      end
      ARB_BUSY: begin
        if (svc_done) begin
          nstate = (ch_waitreq[cur] && req_raw[cur]) ? ARB_HOLD : ARB_IDLE;
        end
      end
      ARB_HOLD: begin
        if (!req_raw[cur]) nstate = ARB_IDLE;
      end
      default: nstate = ARB_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= ARB_IDLE;
      cur   <= '0;
    end else begin
      state <= nstate;
      cur   <= ncur;
    end
  end

  for (genvar i = 0; i < NUM_CH; i++) begin : g_act
    always_ff @(posedge clk) begin
      if (rst) ch_active[i] <= 1'b0;
      else     ch_active[i] <= (nstate != ARB_IDLE) && (ncur == IDX_W'(i));
    end
  end

  assign idle = (state == ARB_IDLE);
endmodule

// File: rtl/dma_req_arbiter.sv
module dma_req_arbiter #(
  parameter int NUM_CH = 8,
  parameter int IDX_W  = $clog2(NUM_CH)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              glb_en,
  input  logic [NUM_CH-1:0] ch_en,
  input  logic [NUM_CH-1:0] ch_mask,
  input  logic [NUM_CH-1:0] ch_burst_only,
  input  logic [NUM_CH-1:0] ch_hipri,
  input  logic [NUM_CH-1:0] ch_waitreq,
  input  logic [NUM_CH-1:0] req_single,
  input  logic [NUM_CH-1:0] req_burst,
  input  logic [NUM_CH-1:0] sw_req,
  input  logic              eng_idle,
  input  logic              svc_done,
  output logic              gnt_valid,
  output logic [IDX_W-1:0]  gnt_ch,
  output logic              gnt_burst,
  output logic [NUM_CH-1:0] ch_active
);
  logic [NUM_CH-1:0] cand, cand_burst, gnt_clr;
  logic              pick_any, trk_idle, gnt_fire;
  logic [IDX_W-1:0]  pick_idx;

  dma_req_qualify #(.NUM_CH(NUM_CH)) u_qual (
    .clk(clk), .rst(rst), .glb_en(glb_en), .ch_en(ch_en), .ch_mask(ch_mask),
    .ch_burst_only(ch_burst_only), .req_single(req_single), .req_burst(req_burst),
    .sw_req(sw_req), .gnt_clr(gnt_clr), .cand(cand), .cand_burst(cand_burst)
  );

  dma_prio_pick #(.NUM_CH(NUM_CH), .IDX_W(IDX_W)) u_pick (
    .cand(cand), .hipri(ch_hipri), .any(pick_any), .idx(pick_idx)
  );

  assign gnt_fire = trk_idle & eng_idle & glb_en & pick_any;

  for (genvar i = 0; i < NUM_CH; i++) begin : g_clr
    assign gnt_clr[i] = gnt_fire && (pick_idx == IDX_W'(i));
  end

  dma_chan_tracker #(.NUM_CH(NUM_CH), .IDX_W(IDX_W)) u_trk (
    .clk(clk), .rst(rst), .start(gnt_fire), .start_idx(pick_idx),
    .svc_done(svc_done), .ch_waitreq(ch_waitreq), .req_raw(req_single | req_burst),
    .idle(trk_idle), .ch_active(ch_active)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      gnt_valid <= 1'b0;
      gnt_ch    <= '0;
      gnt_burst <= 1'b0;
    end else begin
      gnt_valid <= gnt_fire;
      if (gnt_fire) begin
        gnt_ch    <= pick_idx;
        gnt_burst <= cand_burst[pick_idx];
      end
    end
  end
endmodule

// File: rtl/dma_req_arbiter_chk.sv
module dma_req_arbiter_chk #(
  parameter int NUM_CH = 8,
  parameter int IDX_W  = $clog2(NUM_CH)
) (
  input logic              clk,
  input logic              rst,
  input logic              glb_en,
  input logic [NUM_CH-1:0] ch_en,
  input logic              eng_idle,
  input logic              gnt_valid,
  input logic [IDX_W-1:0]  gnt_ch,
  input logic [NUM_CH-1:0] ch_active
);
  logic [NUM_CH-1:0] prev_en;

  always_ff @(posedge clk) begin
    if (rst) prev_en <= '0;
    else     prev_en <= ch_en & {NUM_CH{glb_en}};
  end

  p_active_onehot_r8: assert property (@(posedge clk) disable iff (rst)
    $onehot0(ch_active));

  p_grant_sets_active_r8: assert property (@(posedge clk) disable iff (rst)
    gnt_valid |-> ch_active[gnt_ch]);

  p_grant_when_free_r7: assert property (@(posedge clk) disable iff (rst)
    gnt_valid |-> ($past(eng_idle) && ($past(ch_active) == '0)));

  p_single_strobe_r7: assert property (@(posedge clk) disable iff (rst)
    gnt_valid |=> !gnt_valid);

  p_grant_enabled_r1: assert property (@(posedge clk) disable iff (rst)
    gnt_valid |-> prev_en[gnt_ch]);
endmodule

bind dma_req_arbiter dma_req_arbiter_chk #(.NUM_CH(NUM_CH), .IDX_W(IDX_W)) u_chk (
  .clk(clk), .rst(rst), .glb_en(glb_en), .ch_en(ch_en), .eng_idle(eng_idle),
  .gnt_valid(gnt_valid), .gnt_ch(gnt_ch), .ch_active(ch_active)
);

// File: tb/tb_dma_req_arbiter.sv
`timescale 1ns/1ps
module tb_dma_req_arbiter;
  localparam int N = 8;
  localparam int W = 3;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic glb_en = 1'b1;
  logic [N-1:0] ch_en = '0, ch_mask = '0, ch_burst_only = '0, ch_hipri = '0, ch_waitreq = '0;
  logic [N-1:0] req_single = '0, req_burst = '0, sw_req = '0;
  logic eng_idle = 1'b1, svc_done = 1'b0;
  logic gnt_valid, gnt_burst;
  logic [W-1:0] gnt_ch;
  logic [N-1:0] ch_active;

  int n_cmp = 0, n_bad = 0, cyc = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  dma_req_arbiter #(.NUM_CH(N)) dut (
    .clk(clk), .rst(rst), .glb_en(glb_en), .ch_en(ch_en), .ch_mask(ch_mask),
    .ch_burst_only(ch_burst_only), .ch_hipri(ch_hipri), .ch_waitreq(ch_waitreq),
    .req_single(req_single), .req_burst(req_burst), .sw_req(sw_req),
    .eng_idle(eng_idle), .svc_done(svc_done), .gnt_valid(gnt_valid),
    .gnt_ch(gnt_ch), .gnt_burst(gnt_burst), .ch_active(ch_active)
  );

  function automatic int lowest(input logic [N-1:0] v);
    int r = 0;
    for (int i = N - 1; i >= 0; i--) if (v[i]) r = i;
    return r;
  endfunction

  // Reference model, advanced at the edge from inputs driven at the previous falling edge
  logic [N-1:0] m_pend;
  int m_state, m_cur, m_gc;
  bit m_gv, m_gb;
  logic [N-1:0] t_en, t_c, t_cb, t_hi, t_lvl, t_clr, t_raw;
  int t_pick;
  bit t_fire;

  always @(posedge clk) begin
    if (rst) begin
      m_pend <= '0; m_state <= 0; m_cur <= 0; m_gv <= 0; m_gc <= 0; m_gb <= 0;
    end else begin
      t_en   = ch_en & {N{glb_en}};
      t_c    = ((((req_single & ~ch_burst_only) | req_burst) & ~ch_mask) | m_pend) & t_en;
      t_cb   = req_burst & ~ch_mask & t_en;
      t_hi   = t_c & ch_hipri;
      t_lvl  = (t_hi != 0) ? t_hi : t_c;
      t_pick = lowest(t_lvl);
      t_fire = (m_state == 0) && eng_idle && (t_c != 0);
      t_clr  = t_fire ? (N'(1) << t_pick) : '0;
      t_raw  = req_single | req_burst;
      m_pend <= ((m_pend & ~t_clr) | sw_req) & ch_en;
      m_gv   <= t_fire;
      if (t_fire) begin
        m_gc <= t_pick;
        m_gb <= t_cb[t_pick];
      end
      case (m_state)
        0: if (t_fire) begin m_state <= 1; m_cur <= t_pick; end
        1: if (svc_done) m_state <= (ch_waitreq[m_cur] && t_raw[m_cur]) ? 2 : 0;
        default: if (!t_raw[m_cur]) m_state <= 0;
      endcase
    end
  end

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual=%0d expected=%0d (t=%0t)", tag, act, exp, $time);
    end
  endtask

  // Cycle-by-cycle comparison against the model
  always @(negedge clk) begin
    if (!rst) begin
      logic [N-1:0] exp_act;
      exp_act = (m_state != 0) ? (N'(1) << m_cur) : '0;
      check(gnt_valid == m_gv, "R7 gnt_valid", gnt_valid, m_gv);
      check(ch_active == exp_act, "R8/R9 ch_active", ch_active, exp_act);
      if (m_gv) begin
        check(int'(gnt_ch) == m_gc, "R6/R5 gnt_ch", gnt_ch, m_gc);
        check(gnt_burst == m_gb, "R12 gnt_burst", gnt_burst, m_gb);
      end
    end
  end

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc == 150000 && !finished) begin
      n_bad++;
      $display("FAIL R7 watchdog: actual=%0d expected=%0d", cyc, 0);
      summary();
    end
  end

  task automatic wait_grant(output int ch, output int b, output bit got, input int maxc);
    got = 0; ch = -1; b = -1;
    for (int k = 0; k < maxc && !got; k++) begin
      @(negedge clk);
      if (gnt_valid) begin got = 1; ch = gnt_ch; b = gnt_burst; end
    end
  endtask

  task automatic expect_none(input int n, input string tag);
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      check(!gnt_valid, tag, gnt_valid, 0);
    end
  endtask

  task automatic serve();
    svc_done = 1'b1;
    @(negedge clk);
    svc_done = 1'b0;
  endtask

  task automatic quiet();
    req_single = '0; req_burst = '0; sw_req = '0;
    if (ch_active != 0) serve();
    @(negedge clk);
  endtask

  initial begin
    int ch, b;
    bit got;
    void'($urandom(32'd7001));
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R11 reset state
    check(gnt_valid == 0, "R11 gnt_valid after reset", gnt_valid, 0);
    check(ch_active == 0, "R11 ch_active after reset", ch_active, 0);

    // R1: global and channel enable gate
    glb_en = 0; ch_en = '1; req_burst[2] = 1;
    expect_none(4, "R1 glb_en low");
    glb_en = 1; ch_en[2] = 0;
    expect_none(4, "R1 channel disabled");
    ch_en = '1; quiet();

    // R6: lowest index wins
    req_single = 8'b0101_0000;
    wait_grant(ch, b, got, 5);
    check(got && ch == 4, "R6 lowest index", ch, 4);
    check(ch_active == 8'b0001_0000, "R8 active on grant", ch_active, 8'b0001_0000);
    req_single = '0;
    @(negedge clk);
    check(!gnt_valid, "R7 one-cycle strobe", gnt_valid, 0);
    serve();
    check(ch_active == 0, "R8 release on done", ch_active, 0);
    quiet();

    // R5: high priority beats lower index
    req_single = 8'b0100_0010; ch_hipri[6] = 1;
    wait_grant(ch, b, got, 5);
    check(got && ch == 6, "R5 high level wins", ch, 6);
    ch_hipri = '0; quiet();

    // R3 and R12: burst-only ignores single
    ch_burst_only[1] = 1; req_single[1] = 1;
    expect_none(4, "R3 single ignored");
    req_burst[1] = 1;
    wait_grant(ch, b, got, 5);
    check(got && ch == 1, "R3 burst served", ch, 1);
    check(b == 1, "R12 burst flag set", b, 1);
    ch_burst_only = '0; quiet();

    // R2: mask blocks external, software still counts, not reported as burst
    ch_mask[3] = 1; req_burst[3] = 1;
    expect_none(4, "R2 masked burst ignored");
    sw_req[3] = 1;
    @(negedge clk);
    sw_req = '0;
    wait_grant(ch, b, got, 5);
    check(got && ch == 3, "R2 software through mask", ch, 3);
    check(b == 0, "R12 masked burst not flagged", b, 0);
    req_burst = '0; ch_mask = '0; quiet();

    // R4: pending software request survives a busy engine, one pulse one grant
    eng_idle = 0; sw_req[5] = 1;
    @(negedge clk);
    sw_req = '0;
    expect_none(3, "R4 wait for engine");
    eng_idle = 1;
    wait_grant(ch, b, got, 5);
    check(got && ch == 5 && b == 0, "R4 pending granted", ch, 5);
    serve();
    expect_none(4, "R4 pending cleared by grant");

    // R10: disabling drops the pending software request
    eng_idle = 0; sw_req[7] = 1;
    @(negedge clk);
    sw_req = '0; ch_en[7] = 0;
    @(negedge clk);
    ch_en = '1; eng_idle = 1;
    expect_none(5, "R10 pending dropped");

    // R9: handshake hold blocks other channels until request drops
    ch_waitreq[0] = 1; req_single[0] = 1;
    wait_grant(ch, b, got, 5);
    check(got && ch == 0, "R9 grant ch0", ch, 0);
    req_single[2] = 1;
    serve();
    check(ch_active == 8'b0000_0001, "R9 held after done", ch_active, 1);
    expect_none(3, "R9 no grant during hold");
    check(ch_active == 8'b0000_0001, "R9 still held", ch_active, 1);
    req_single[0] = 0;
    @(negedge clk);
    check(ch_active == 0, "R9 released on drop", ch_active, 0);
    wait_grant(ch, b, got, 5);
    check(got && ch == 2, "R9 next channel after release", ch, 2);
    ch_waitreq = '0; quiet();

    // Random phase
    for (int k = 0; k < 6000; k++) begin
      if ($urandom % 8 == 0) begin
        ch_en = N'($urandom) | N'($urandom);
        ch_mask = N'($urandom) & N'($urandom);
        ch_burst_only = N'($urandom) & N'($urandom);
        ch_hipri = N'($urandom) & N'($urandom);
        ch_waitreq = N'($urandom);
        glb_en = ($urandom % 16) != 0;
      end
      if ($urandom % 3 == 0) begin
        req_single = N'($urandom) & N'($urandom);
        req_burst = N'($urandom) & N'($urandom) & N'($urandom);
      end
      sw_req = ($urandom % 4 == 0) ? (N'(1) << ($urandom % N)) : '0;
      eng_idle = ($urandom % 8) != 0;
      svc_done = (ch_active != 0) && ($urandom % 3 == 0);
      @(negedge clk);
    end
    finished = 1;
    summary();
  end
endmodule